// File: doc/BRIEF.md
# Interruptible Block-Copy Engine

This unit sits inside a processor core and carries out a single block-copy instruction. When the control unit issues a start strobe, the engine reads six parameter bytes from the stack region. These bytes are a 16-bit count, a 16-bit source address and a 16-bit destination address. The engine then copies bytes with a tight two-cycle loop of one read followed by one write. The copy walks downward: it starts at offset `count` and ends at offset 0, so it moves `count + 1` bytes. After the last byte it raises a one-cycle completion pulse so that the instruction can retire.

A persistent progress flag marks that the parameter phase has finished. An interrupt stops the engine at the next loop-iteration boundary and leaves the flag and the working registers alone. When the instruction executes again, the engine goes straight back to the copy loop and does not read the stack a second time. An interrupt that arrives while parameters are still being read simply abandons the attempt, so the next start begins from scratch. Abort always clears the flag and throws away any progress. The surrounding core must hold the stack pointer steady while parameters are read, because every parameter address is formed from its live value.

Top module: `blkcopy_engine`

## Requirements
- R1: After reset the engine is idle (`active`=0), `busy`=0, `done`=0, and neither `mem_re` nor `mem_we` is asserted.
- R2: After a start with `busy`=0, the engine reads `sp+offset+k` for k = 0 to 5 in six consecutive cycles, beginning in the cycle after the strobe is sampled. The sum is 16 bits and wraps. The bytes, in order, are count low, count high, source low, source high, destination low, destination high.
- R3: The copy loop handles k = count down to 0. For each k it reads `src+k` in one cycle and writes that byte to `dst+k` in the next cycle. All addresses wrap modulo 65536. Overlapping regions therefore behave as a high-to-low copy.
- R4: On a fresh run, `done` pulses for exactly one cycle, 7+2·(count+1) cycles after the start edge. At that point `busy` and `active` are 0.
- R5: `busy` rises in the cycle in which the first loop read is issued, which is 7 cycles after a fresh start.
- R6: `irq` is sampled only at the end of a write cycle whose k is nonzero. The engine then goes idle without `done`, with `busy` still 1, and the paired write of any started read always completes.
- R7: A start while `busy`=1 reads no stack bytes. It issues the loop read for the remaining k in the cycle after the strobe and finishes the remaining bytes. `done` follows 2·(remaining) cycles after the start edge.
- R8: `irq` or `abort` during the parameter reads abandons the instruction. `busy` stays 0, no byte is written, and the next start reads all parameters again.
- R9: `abort` at a loop boundary, or while the engine is idle, clears `busy`, so that the next start reads all parameters again.
- R10: A start strobe while the engine is active is ignored.
- R11: `mem_re` and `mem_we` are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction start strobe |
| offset | input | 8 | Stack offset of the parameter block |
| sp | input | 16 | Current stack pointer |
| irq | input | 1 | Interrupt request, level |
| abort | input | 1 | Abort request, level |
| mem_re | output | 1 | Memory read enable; data returns one cycle later |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data from the previous cycle's read |
| active | output | 1 | Engine is running |
| busy | output | 1 | Parameter phase finished and copy not yet complete |
| done | output | 1 | One-cycle completion event to the control unit |

## Verification
A corrupted progress flag makes a restarted instruction either read the stack again or skip the reads. Either fault appears on `mem_addr` in the first cycle after the strobe, and it also shows in the destination contents when the stack bytes have changed in between. A count or address register that drifts writes a wrong byte or hits a wrong location. That error is visible on the next write cycle and shows up as a mismatch in the memory image. A sequencer that samples interrupts at the wrong point shows up as a stop one cycle early or late and as a partial copy with a wrong byte count.

// File: rtl/blkcopy_engine.sv
module blkcopy_engine #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] offset,
  input  logic [AW-1:0] sp,
  input  logic          irq,
  input  logic          abort,
  output logic          mem_re,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          active,
  output logic          busy,
  output logic          done
);
  localparam int OW  = 3 * AW;
  localparam int OPB = OW / DW;
  localparam int IW  = $clog2(OPB + 1);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_RD, S_WR} st_t;

  st_t           st;
  logic [IW-1:0] idx;
  logic [OW-1:0] opr;
  logic          busy_q, done_q;

  wire [AW-1:0] cnt  = opr[AW-1:0];
  wire [AW-1:0] src  = opr[2*AW-1:AW];
  wire [AW-1:0] dst  = opr[OW-1:2*AW];
  wire [AW-1:0] base = sp + AW'(offset);
  wire          fetch_rd = (st == S_FETCH) && (idx < IW'(OPB));

  assign mem_re    = fetch_rd || (st == S_RD);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = (st == S_FETCH) ? base + AW'(idx) :
                     (st == S_RD)    ? src + cnt : dst + cnt;
  assign mem_wdata = mem_rdata;
  assign active    = (st != S_IDLE);
  assign busy      = busy_q;
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      idx    <= '0;
      opr    <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (abort) busy_q <= 1'b0;
          else if (start) begin
            idx <= '0;
            st  <= busy_q ? S_RD : S_FETCH;
          end
        end
        S_FETCH: begin
          if (idx != '0) opr <= {mem_rdata, opr[OW-1:DW]};
          if (idx == IW'(OPB)) begin
            busy_q <= 1'b1;
            st     <= S_RD;
          end else if (irq || abort) st <= S_IDLE;
          else idx <= idx + 1'b1;
        end
        S_RD: st <= S_WR;
        default: begin
          if (cnt == '0) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            opr[AW-1:0] <= cnt - 1'b1;
            if (abort) begin
              busy_q <= 1'b0;
              st     <= S_IDLE;
            end else if (irq) st <= S_IDLE;
            else st <= S_RD;
          end
        end
      endcase
    end
  end

  // R11
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  // R3
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(mem_re));

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !active));

  // R5
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mem_re && active));

  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !active) |=> !busy);

  // R6
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || $past(abort)));
endmodule

// File: tb/blkcopy_engine_tb_top.sv
module blkcopy_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, irq = 1'b0, abort = 1'b0;
  logic [7:0]  offset = '0;
  logic [15:0] sp = '0;
  logic        mem_re, mem_we, active, busy, done;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  int total = 0, bad = 0, wd = 0;

  logic [7:0] mem [4096];
  logic [7:0] exp_m [4096];
  logic       fill_req = 1'b0, tb_we = 1'b0;
  logic [15:0] tb_a = '0;
  logic [7:0]  tb_d = '0;

  always #4 clk = ~clk;

  blkcopy_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .offset(offset), .sp(sp),
    .irq(irq), .abort(abort), .mem_re(mem_re), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .active(active), .busy(busy), .done(done));

  function automatic logic [7:0] pat(int i);
    return 8'((i * 7 + 3) ^ (i >> 4));
  endfunction

  always @(posedge clk) begin
    if (fill_req) begin
      for (int i = 0; i < 4096; i++) mem[i] <= pat(i);
    end else begin
      if (tb_we) mem[tb_a[11:0]] <= tb_d;
      if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    end
    if (mem_re) mem_rdata <= mem[mem_addr[11:0]];
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", wd, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic init_mem();
    @(negedge clk) fill_req = 1'b1;
    @(negedge clk) fill_req = 1'b0;
    for (int i = 0; i < 4096; i++) exp_m[i] = pat(i);
  endtask

  task automatic poke(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk) begin tb_we = 1'b1; tb_a = a; tb_d = d; end
    @(negedge clk) tb_we = 1'b0;
    exp_m[a[11:0]] = d;
  endtask

  task automatic put_ops(input logic [15:0] b, input logic [15:0] c,
                         input logic [15:0] s, input logic [15:0] d);
    poke(b,       c[7:0]);  poke(b + 16'd1, c[15:8]);
    poke(b + 16'd2, s[7:0]); poke(b + 16'd3, s[15:8]);
    poke(b + 16'd4, d[7:0]); poke(b + 16'd5, d[15:8]);
  endtask

  task automatic model(input logic [15:0] c, input logic [15:0] s,
                       input logic [15:0] d, input int nb);
    logic [15:0] k = c;
    for (int n = 0; n < nb; n++) begin
      exp_m[16'(d + k) & 16'hFFF] = exp_m[16'(s + k) & 16'hFFF];
      k = k - 16'd1;
    end
  endtask

  task automatic cmp_all(input string tag);
    int bad_i = -1;
    for (int i = 0; i < 4096; i++)
      if (bad_i < 0 && mem[i] !== exp_m[i]) bad_i = i;
    if (bad_i < 0) check(1'b1, tag, 0, 0);
    else check(1'b0, tag, int'(mem[bad_i]), int'(exp_m[bad_i]));
  endtask

  task automatic run(input bit fetch, input logic [15:0] a0,
                     input int irq_at, input int abort_at, input int start_at,
                     output int cyc, output bit got_done);
    @(negedge clk) start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    cyc = 0;
    while (active && cyc < 5000) begin
      if (cyc == 0)
        check(mem_re && !mem_we && mem_addr == a0, "R2/R7 first read", int'(mem_addr), int'(a0));
      if (fetch && cyc > 0 && cyc < 6)
        check(mem_re && mem_addr == a0 + 16'(cyc), "R2 operand address", int'(mem_addr), int'(a0 + 16'(cyc)));
      if (fetch && cyc == 6) check(!busy, "R5 busy before loop", busy, 0);
      if (fetch && cyc == 7) check(busy, "R5 busy at loop start", busy, 1);
      if (cyc == irq_at) irq = 1'b1;
      if (cyc == abort_at) abort = 1'b1;
      if (cyc == start_at) start = 1'b1;
      if (cyc == start_at + 1) start = 1'b0;
      @(posedge clk); #1;
      cyc++;
    end
    got_done = done;
    irq = 1'b0; abort = 1'b0; start = 1'b0;
  endtask

  localparam logic [71:0] VEC [6] = '{
    {16'h0100, 8'h00, 16'h0000, 16'h0200, 16'h0300},
    {16'h0180, 8'h20, 16'h0007, 16'h0210, 16'h0340},
    {16'h01FF, 8'hFF, 16'h0003, 16'h0400, 16'h0500},
    {16'h0100, 8'h40, 16'h0005, 16'h0600, 16'h0602},
    {16'hFFFA, 8'h08, 16'h0004, 16'hFFFE, 16'h0700},
    {16'h0100, 8'h80, 16'h0010, 16'h0800, 16'h0900}
  };

  initial begin
    int cyc;
    bit gd;
    logic [15:0] b;
    repeat (3) @(posedge clk);
    #1;
    check(!active && !busy && !done && !mem_re && !mem_we, "R1 reset state",
          {active, busy, done, mem_re, mem_we}, 0);
    rst_n = 1'b1;

    for (int v = 0; v < 6; v++) begin
      logic [71:0] e = VEC[v];
      init_mem();
      sp = e[71:56]; offset = e[55:48];
      b = e[71:56] + 16'(e[55:48]);
      put_ops(b, e[47:32], e[31:16], e[15:0]);
      model(e[47:32], e[31:16], e[15:0], int'(e[47:32]) + 1);
      run(1'b1, b, -1, -1, (v == 1) ? 9 : -1, cyc, gd);
      check(gd, "R4 done pulse", gd, 1);
      check(cyc == 7 + 2 * (int'(e[47:32]) + 1), (v == 1) ? "R10 timing with stray start" : "R4 done timing",
            cyc, 7 + 2 * (int'(e[47:32]) + 1));
      check(!busy, "R4 busy cleared", busy, 0);
      @(posedge clk); #1;
      check(!done && !active, "R4 done single cycle", done, 0);
      cmp_all((v == 4) ? "R3 address wrap copy" : (v == 3) ? "R3 overlap copy" : "R3 copy result");
    end

    // R6, R7: interrupt mid loop, then resume without refetch
    init_mem();
    sp = 16'h0100; offset = 8'h00; b = 16'h0100;
    put_ops(b, 16'd9, 16'h0A00, 16'h0B00);
    run(1'b1, b, 9, -1, -1, cyc, gd);
    check(cyc == 11 && !gd, "R6 stop at boundary", cyc, 11);
    check(busy, "R6 busy kept", busy, 1);
    model(16'd9, 16'h0A00, 16'h0B00, 2);
    cmp_all("R6 partial copy");
    put_ops(b, 16'd1, 16'h0A40, 16'h0C00);
    run(1'b0, 16'h0A07, -1, -1, -1, cyc, gd);
    check(gd && cyc == 16, "R7 resume timing", cyc, 16);
    model(16'd7, 16'h0A00, 16'h0B00, 8);
    cmp_all("R7 resume result");

    // R8: interrupt during parameter reads, then abort during reads
    init_mem();
    put_ops(b, 16'd3, 16'h0A00, 16'h0B00);
    run(1'b1, b, 2, -1, -1, cyc, gd);
    check(cyc == 3 && !gd && !busy, "R8 irq abandons fetch", cyc, 3);
    cmp_all("R8 nothing written");
    run(1'b1, b, -1, 4, -1, cyc, gd);
    check(cyc == 5 && !gd && !busy, "R8 abort abandons fetch", cyc, 5);
    run(1'b1, b, -1, -1, -1, cyc, gd);
    check(gd && cyc == 15, "R8 full restart timing", cyc, 15);
    model(16'd3, 16'h0A00, 16'h0B00, 4);
    cmp_all("R8 restart result");

    // R9: abort at loop boundary discards progress
    init_mem();
    put_ops(b, 16'd9, 16'h0A00, 16'h0B00);
    run(1'b1, b, -1, 10, -1, cyc, gd);
    check(cyc == 11 && !gd && !busy, "R9 abort in loop", busy, 0);
    model(16'd9, 16'h0A00, 16'h0B00, 2);
    put_ops(b, 16'd2, 16'h0A00, 16'h0C00);
    run(1'b1, b, -1, -1, -1, cyc, gd);
    check(gd && cyc == 13, "R9 refetch after abort", cyc, 13);
    model(16'd2, 16'h0A00, 16'h0C00, 3);
    cmp_all("R9 result after abort");

    // R9: abort while idle with busy set
    init_mem();
    put_ops(b, 16'd9, 16'h0A00, 16'h0B00);
    run(1'b1, b, 8, -1, -1, cyc, gd);
    check(busy, "R6 busy kept before idle abort", busy, 1);
    @(negedge clk) abort = 1'b1;
    @(posedge clk); #1 abort = 1'b0;
    check(!busy, "R9 idle abort clears busy", busy, 0);
    run(1'b1, b, -1, -1, -1, cyc, gd);
    check(gd && cyc == 27, "R9 full rerun timing", cyc, 27);
    model(16'd9, 16'h0A00, 16'h0B00, 10);
    cmp_all("R9 full rerun result");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule